// File: doc/BRIEF.md
# Dual Delay-and-Width Gate Generator

This block turns short trigger pulses into gate windows for a pair of analog stretcher banks. Each of its two generators waits a programmable delay after a trigger and then holds its gate high for a programmable width. A fast-clear input aborts both generators at once, in either phase. The delay code is non-linear: the smallest code gives a very short delay, and the codes above it count up in coarse steps from a fixed base.

The generators can be used in three ways. With the banks joined, only generator 0 runs. With the banks independent, each trigger line feeds its own generator. In toggle mode, triggers on line 0 go to the two generators in turn, so that one bank can accept a new gate while the other is still busy. The block runs on a 40 MHz clock, so one cycle is 25 ns. All delays and widths below are given in cycles.

Top module: `gate_pair_gen`

## Requirements
- R1: The delay counts from the clock edge that samples the trigger's rising edge. With delay code 0 the gate rises 1 cycle after that edge. With code n ≥ 1 it rises 2n+4 cycles after it, which is 150 ns plus (n−1)×50 ns.
- R2: The gate stays high for 2×w cycles, where w is the 8-bit width code. The generator's busy flag is high from the trigger-sampling edge to the end of its gate. The delay and width codes are captured when the generator starts.
- R3: With width code 0 the generator raises no gate. Its busy flag is high for exactly the delay cycles, and then it returns to idle.
- R4: When fast clear is high at a clock edge, both gates and both busy flags are low after that edge. A trigger sampled in the same cycle starts nothing and raises no lost flag.
- R5: Only a rising edge starts a generator. A trigger held high starts at most one gate.
- R6: The generator-select field enables generator 0 with bit 0 and generator 1 with bit 1. A trigger aimed at a disabled generator is ignored and raises no lost flag.
- R7: With bank mode 00 (joined), trigger line 1 is ignored and generator 1 never starts, whatever the select field holds.
- R8: With bank mode 01 or 10 (independent), trigger line 0 drives generator 0 and trigger line 1 drives generator 1.
- R9: With bank mode 11 (toggle), trigger line 1 is ignored. Edges on line 0 start the generator named by a turn pointer, which is 0 after reset and is set to the other generator after each start. If the named generator is busy or disabled, the other one starts if it is enabled and free.
- R10: A trigger whose target is busy (in toggle mode: no enabled generator is free) is dropped. It raises the lost flag for exactly one cycle, after the edge that sampled it.
- R11: During and directly after reset, the gates, busy flags and lost flag are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 2 | Trigger lines 0 and 1 |
| fclr_i | input | 1 | Fast clear, aborts both generators |
| dly_code0_i | input | 8 | Delay code of generator 0 |
| wid_code0_i | input | 8 | Width code of generator 0 |
| dly_code1_i | input | 8 | Delay code of generator 1 |
| wid_code1_i | input | 8 | Width code of generator 1 |
| gen_sel_i | input | 2 | Generator enables, bit 0 for generator 0 and bit 1 for generator 1 |
| bank_mode_i | input | 2 | 00 joined, 01/10 independent, 11 toggle |
| gate_o | output | 2 | Gate of each generator |
| busy_o | output | 2 | Busy flag of each generator |
| lost_o | output | 1 | One-cycle pulse for a dropped trigger |

## Verification
A start, a clear and a lost flag each show at the ports one clock edge after the trigger or clear is sampled. A gate rises after the full delay count (1 or 2n+4 cycles) and falls 2w cycles after that. The bench's behavioural model advances on the same edge as the design, and the outputs are compared at the falling edge of every cycle, so each result is checked in the exact cycle it is due. Directed checks also sample the first gate edge for the shortest delay one and two cycles after the trigger.

// File: rtl/dgg_pkg.sv
package dgg_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_DLY  = 2'd1,
    PH_WID  = 2'd2
  } phase_e;

  localparam logic [1:0] MODE_JOINED = 2'b00;
  localparam logic [1:0] MODE_TOGGLE = 2'b11;
endpackage

// File: rtl/dgg_channel.sv
module dgg_channel
  import dgg_pkg::*;
#(
  parameter int CODE_W    = 8,
  parameter int SHORT_DLY = 1,
  parameter int BASE_DLY  = 6,
  parameter int DLY_STEP  = 2,
  parameter int WID_STEP  = 2,
  parameter int CNT_W     = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              clear_i,
  input  logic [CODE_W-1:0] dly_code_i,
  input  logic [CODE_W-1:0] wid_code_i,
  output logic              gate_o,
  output logic              busy_o
);
  phase_e              phase_q, phase_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [CODE_W-1:0]   wid_q, wid_d;
  logic [CNT_W-1:0]    dly_cyc, wid_cyc;

  // non-linear delay code to cycle count
  always_comb begin
    if (dly_code_i == '0)
      dly_cyc = CNT_W'(SHORT_DLY);
    else
      dly_cyc = CNT_W'(BASE_DLY) + CNT_W'(DLY_STEP) * (CNT_W'(dly_code_i) - CNT_W'(1));
    wid_cyc = CNT_W'(WID_STEP) * CNT_W'(wid_q);
  end

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    wid_d   = wid_q;
    if (clear_i) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
    end else begin
      case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_d = PH_DLY;
          cnt_d   = dly_cyc - CNT_W'(1);
          wid_d   = wid_code_i;
        end
        PH_DLY: begin
          if (cnt_q == '0) begin
            if (wid_q == '0) begin
              phase_d = PH_IDLE;
            end else begin
              phase_d = PH_WID;
              cnt_d   = wid_cyc - CNT_W'(1);
            end
          end else begin
            cnt_d = cnt_q - CNT_W'(1);
          end
        end
        PH_WID: begin
          if (cnt_q == '0) phase_d = PH_IDLE;
          else             cnt_d   = cnt_q - CNT_W'(1);
        end
        default: phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      wid_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      wid_q   <= wid_d;
    end
  end

  assign gate_o = (phase_q == PH_WID);
  assign busy_o = (phase_q != PH_IDLE);

  AST_CLEAR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> !busy_o); // R4
  AST_START_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_o); // R10
  AST_ZERO_WIDTH_NO_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DLY && wid_q == '0) |=> !gate_o); // R3
  AST_GATE_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    gate_o |-> busy_o); // R2
endmodule

// File: rtl/dgg_router.sv
module dgg_router
  import dgg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] trig_i,
  input  logic       clear_i,
  input  logic [1:0] sel_i,
  input  logic [1:0] mode_i,
  input  logic [1:0] busy_i,
  output logic [1:0] start_o,
  output logic       lost_o
);
  logic [1:0] trig_q;
  logic       ptr_q, ptr_d;
  logic       lost_q, lost_d;
  logic [1:0] edge_w, en_w, free_w;

  assign edge_w = trig_i & ~trig_q;
  assign en_w   = {sel_i[1] && (mode_i != MODE_JOINED), sel_i[0]};
  assign free_w = en_w & ~busy_i;

  always_comb begin
    start_o = '0;
    lost_d  = 1'b0;
    ptr_d   = ptr_q;
    if (!clear_i) begin
      if (mode_i == MODE_TOGGLE) begin
        if (edge_w[0]) begin
          if (free_w[ptr_q]) begin
            start_o[ptr_q] = 1'b1;
            ptr_d          = ~ptr_q;
          end else if (free_w[~ptr_q]) begin
            start_o[~ptr_q] = 1'b1;
          end else if (|en_w) begin
            lost_d = 1'b1;
          end
        end
      end else begin
        for (int g = 0; g < 2; g++) begin
          if (edge_w[g] && en_w[g]) begin
            if (busy_i[g]) lost_d     = 1'b1;
            else           start_o[g] = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= '0;
      ptr_q  <= 1'b0;
      lost_q <= 1'b0;
    end else begin
      trig_q <= trig_i;
      ptr_q  <= ptr_d;
      lost_q <= lost_d;
    end
  end

  assign lost_o = lost_q;

  AST_JOINED_NO_GEN1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_JOINED) |-> !start_o[1]); // R7
  AST_TOGGLE_ONE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_TOGGLE) |-> $onehot0(start_o)); // R9
  AST_CLEAR_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |-> (start_o == 2'b00)); // R4
  AST_LOST_AFTER_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    lost_o |-> $past(|trig_i)); // R10
endmodule

// File: rtl/gate_pair_gen.sv
module gate_pair_gen #(
  parameter int CODE_W    = 8,
  parameter int SHORT_DLY = 1,
  parameter int BASE_DLY  = 6,
  parameter int DLY_STEP  = 2,
  parameter int WID_STEP  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        trig_i,
  input  logic              fclr_i,
  input  logic [CODE_W-1:0] dly_code0_i,
  input  logic [CODE_W-1:0] wid_code0_i,
  input  logic [CODE_W-1:0] dly_code1_i,
  input  logic [CODE_W-1:0] wid_code1_i,
  input  logic [1:0]        gen_sel_i,
  input  logic [1:0]        bank_mode_i,
  output logic [1:0]        gate_o,
  output logic [1:0]        busy_o,
  output logic              lost_o
);
  localparam int MAX_CODE = (1 << CODE_W) - 1;
  localparam int MAX_DLY  = BASE_DLY + DLY_STEP * MAX_CODE;
  localparam int MAX_WID  = WID_STEP * MAX_CODE;
  localparam int MAX_CYC  = (MAX_DLY > MAX_WID) ? MAX_DLY : MAX_WID;
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  logic [1:0]        start_w;
  logic [CODE_W-1:0] dly_arr [2];
  logic [CODE_W-1:0] wid_arr [2];

  assign dly_arr[0] = dly_code0_i;
  assign dly_arr[1] = dly_code1_i;
  assign wid_arr[0] = wid_code0_i;
  assign wid_arr[1] = wid_code1_i;

  dgg_router u_router (
    .clk     (clk),
    .rst_n   (rst_n),
    .trig_i  (trig_i),
    .clear_i (fclr_i),
    .sel_i   (gen_sel_i),
    .mode_i  (bank_mode_i),
    .busy_i  (busy_o),
    .start_o (start_w),
    .lost_o  (lost_o)
  );

  for (genvar g = 0; g < 2; g++) begin : g_chan
    dgg_channel #(
      .CODE_W    (CODE_W),
      .SHORT_DLY (SHORT_DLY),
      .BASE_DLY  (BASE_DLY),
      .DLY_STEP  (DLY_STEP),
      .WID_STEP  (WID_STEP),
      .CNT_W     (CNT_W)
    ) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_w[g]),
      .clear_i    (fclr_i),
      .dly_code_i (dly_arr[g]),
      .wid_code_i (wid_arr[g]),
      .gate_o     (gate_o[g]),
      .busy_o     (busy_o[g])
    );
  end
endmodule

// File: tb/gate_pair_gen_tb.sv
module gate_pair_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] trig;
  logic       fclr;
  logic [7:0] dly0, wid0, dly1, wid1;
  logic [1:0] sel, mode;
  logic [1:0] gate, busy;
  logic       lost;

  int    checks = 0;
  int    fails  = 0;
  int    cyc    = 0;
  bit    done   = 1'b0;
  string cur_req = "R11";

  // behavioural reference: phase 0 idle, 1 delay, 2 width
  int ph [2];
  int rem[2];
  int wc [2];
  int ptr;
  bit lost_m;
  bit tq [2];

  always #5 clk = ~clk;

  gate_pair_gen u_dut (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .fclr_i(fclr),
    .dly_code0_i(dly0), .wid_code0_i(wid0), .dly_code1_i(dly1), .wid_code1_i(wid1),
    .gen_sel_i(sel), .bank_mode_i(mode), .gate_o(gate), .busy_o(busy), .lost_o(lost)
  );

  function automatic int dcyc(input int c);
    return (c == 0) ? 1 : 6 + 2 * (c - 1);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < 2; g++) begin ph[g] = 0; rem[g] = 0; wc[g] = 0; tq[g] = 0; end
      ptr = 0; lost_m = 0;
    end else begin
      bit e[2], b[2], en[2], st[2], ln, f0, f1;
      int dc[2], wcd[2];
      dc[0] = dly0; dc[1] = dly1; wcd[0] = wid0; wcd[1] = wid1;
      for (int g = 0; g < 2; g++) begin
        e[g] = trig[g] && !tq[g]; tq[g] = trig[g]; b[g] = (ph[g] != 0); st[g] = 0;
      end
      ln = 0;
      en[0] = sel[0]; en[1] = sel[1] && (mode != 2'b00);
      if (!fclr) begin
        if (mode == 2'b11) begin
          if (e[0]) begin
            f0 = en[0] && !b[0]; f1 = en[1] && !b[1];
            if ((ptr == 0) ? f0 : f1) begin st[ptr] = 1; ptr = 1 - ptr; end
            else if ((ptr == 0) ? f1 : f0) st[1 - ptr] = 1;
            else if (en[0] || en[1]) ln = 1;
          end
        end else begin
          for (int g = 0; g < 2; g++)
            if (e[g] && en[g]) begin if (b[g]) ln = 1; else st[g] = 1; end
        end
      end
      for (int g = 0; g < 2; g++) begin
        if (fclr) ph[g] = 0;
        else if (ph[g] == 1) begin
          rem[g]--;
          if (rem[g] == 0) begin
            if (wc[g] == 0) ph[g] = 0; else begin ph[g] = 2; rem[g] = 2 * wc[g]; end
          end
        end else if (ph[g] == 2) begin
          rem[g]--;
          if (rem[g] == 0) ph[g] = 0;
        end
        if (st[g]) begin ph[g] = 1; rem[g] = dcyc(dc[g]); wc[g] = wcd[g]; end
      end
      lost_m = ln;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      logic [1:0] eg, eb;
      eg = {ph[1] == 2, ph[0] == 2};
      eb = {ph[1] != 0, ph[0] != 0};
      checks++;
      if (gate !== eg || busy !== eb || lost !== lost_m) begin
        fails++;
        $display("FAIL %s cycle %0d: gate=%b busy=%b lost=%b expected gate=%b busy=%b lost=%b",
                 cur_req, cyc, gate, busy, lost, eg, eb, lost_m);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int b);
    @(negedge clk); trig[b] = 1'b1;
    @(negedge clk); trig[b] = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; trig = '0; fclr = 1'b0;
    dly0 = 8'd20; wid0 = 8'd50; dly1 = 8'd20; wid1 = 8'd50;
    sel = 2'b01; mode = 2'b00;
    idle(3);
    cur_req = "R11";
    chk(gate == 2'b00 && busy == 2'b00 && lost == 1'b0, "R11 reset", {gate, busy, lost}, 0);
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    chk(gate == 2'b00 && busy == 2'b00 && lost == 1'b0, "R11 after reset", {gate, busy, lost}, 0);

    // R1 R2 with the power-up codes 20 and 50
    cur_req = "R1/R2 codes 20,50";
    pulse(0); idle(160);

    // R1 shortest delay: gate one cycle after the sampling edge
    cur_req = "R1 code 0";
    dly0 = 8'd0; wid0 = 8'd3;
    pulse(0);
    chk(gate[0] == 1'b0, "R1 gate before delay", gate[0], 0);
    @(negedge clk);
    chk(gate[0] == 1'b1, "R1 gate after 1 cycle", gate[0], 1);
    idle(10);
    cur_req = "R1 code 1";
    dly0 = 8'd1; wid0 = 8'd2; pulse(0); idle(15);
    cur_req = "R1 code 3";
    dly0 = 8'd3; wid0 = 8'd1; pulse(0); idle(3);
    dly0 = 8'd7; wid0 = 8'd9; idle(20);   // codes captured at start (R2)

    cur_req = "R3 width 0";
    dly0 = 8'd2; wid0 = 8'd0; pulse(0); idle(15);

    cur_req = "R5 held trigger";
    dly0 = 8'd0; wid0 = 8'd1;
    @(negedge clk); trig[0] = 1'b1; idle(20); trig[0] = 1'b0; idle(5);

    cur_req = "R10 busy target";
    dly0 = 8'd2; wid0 = 8'd3;
    pulse(0); pulse(0); pulse(0); idle(20);

    cur_req = "R4 clear in delay";
    dly0 = 8'd4; wid0 = 8'd4;
    pulse(0); idle(2);
    @(negedge clk); fclr = 1'b1; @(negedge clk); fclr = 1'b0;
    chk(busy[0] == 1'b0, "R4 busy after clear", busy[0], 0);
    idle(3);
    cur_req = "R4 clear in width";
    pulse(0); idle(14);
    @(negedge clk); fclr = 1'b1; @(negedge clk); fclr = 1'b0; idle(3);
    cur_req = "R4 trigger with clear";
    @(negedge clk); fclr = 1'b1; trig[0] = 1'b1;
    @(negedge clk); fclr = 1'b0; trig[0] = 1'b0;
    chk(busy[0] == 1'b0, "R4 trigger with clear ignored", busy[0], 0);
    idle(25);

    cur_req = "R6 none selected";
    dly0 = 8'd0; wid0 = 8'd2; dly1 = 8'd0; wid1 = 8'd2;
    sel = 2'b00; mode = 2'b01;
    pulse(0); pulse(1); idle(6);
    cur_req = "R6 only gen1";
    sel = 2'b10; pulse(0); idle(2); pulse(1); idle(8);

    cur_req = "R7 joined";
    sel = 2'b11; mode = 2'b00;
    pulse(1); idle(4); pulse(0); idle(8);

    cur_req = "R8 independent";
    mode = 2'b01; dly1 = 8'd1; wid1 = 8'd3;
    pulse(0); pulse(1); idle(20);
    mode = 2'b10;
    @(negedge clk); trig = 2'b11; @(negedge clk); trig = 2'b00; idle(20);

    cur_req = "R9 toggle";
    mode = 2'b11; dly0 = 8'd1; wid0 = 8'd2; dly1 = 8'd1; wid1 = 8'd2;
    pulse(0); idle(12); pulse(0); idle(12); pulse(0); idle(12);
    pulse(1); idle(4);
    cur_req = "R10 toggle both busy";
    pulse(0); pulse(0); pulse(0); idle(15);
    cur_req = "R9 toggle one enabled";
    sel = 2'b01; pulse(0); pulse(0); idle(15);

    finish_run();
  end
endmodule